// File: doc/BRIEF.md
# Sense-Reversing Barrier

This block holds a group of `P` participants at a hardware barrier and lets them all go once the whole group has arrived. Each participant owns one sense bit and the barrier owns one shared flag. Entering the barrier flips the participant's own sense bit and adds it to a shared arrival counter. The arrival that completes the group clears the counter and copies its own sense value into the shared flag. A participant may go on whenever its sense bit equals the shared flag.

The expected sense flips with every episode, so the barrier can be used again at once. A participant that has been released may enter the next episode while slower participants are still leaving the current one, and no reset phase is needed between episodes. A participant signals entry by pulsing its `arrive` bit for one cycle. It waits while its `proceed` bit is low. The block raises `episodeDone` for one cycle when an episode closes. It raises `arriveErr` for a participant that pulses `arrive` again while it is still held.

Top module: `sense_barrier`

## Requirements
- R1: After reset the shared flag, every sense bit and the counter are 0, so every `proceed` bit is 1 and `episodeDone` and `arriveErr` are 0.
- R2: An accepted arrival flips that participant's sense bit at the clock edge that samples it. Unless that arrival closes the episode, the participant's `proceed` bit is 0 from the next cycle until the episode closes.
- R3: All arrivals accepted in one cycle are counted, and the counter advances by their number.
- R4: When accepted arrivals bring the count to `P`, the counter returns to 0 and the shared flag takes the new sense value. Every `proceed` bit is 1 in the next cycle, including that of the last arriver, whose `proceed` never drops.
- R5: `episodeDone` is 1 for exactly the cycle after the edge at which an episode closes, and is 0 otherwise.
- R6: An `arrive` pulse from a participant whose `proceed` bit is 0 is rejected. Its `arriveErr` bit is 1 in the following cycle.
- R7: A rejected arrival changes neither the counter nor any sense bit. This shows at the ports because the episode still needs exactly the missing participants to close.
- R8: A released participant may arrive for the next episode while others are still released or in the same cycle as the closing arrival's release, and it is held correctly in the new episode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| arrive | input | P | One-cycle entry pulse per participant |
| proceed | output | P | 1 when the participant's sense matches the shared flag |
| episodeDone | output | 1 | One-cycle pulse after an episode closes |
| arriveErr | output | P | One-cycle pulse after a rejected entry |

## Verification
The hardest cases to reach are cycles that mix outcomes. In one such cycle, one participant is rejected while others finish the episode together. In another, all `P` participants enter together in consecutive cycles, so episodes close back to back and `episodeDone` stays high over several cycles. The stimulus builds these cases on purpose. It first parks some participants in a waiting state. It then drives arrival vectors that combine the last needed arrivals with duplicates from waiting participants. It ends with a run of all-ones vectors, and with a pseudo-random arrival sequence compared against a behavioural model on every cycle.

// File: rtl/sense_barrier_pkg.sv
package sense_barrier_pkg;
  typedef struct packed {
    logic closeEpisode;
    logic anyAccept;
  } barStrobe_t;
endpackage

// File: rtl/sense_barrier_ctrl.sv
module sense_barrier_ctrl
  import sense_barrier_pkg::*;
#(
  parameter int P = 4,
  localparam int CW = $clog2(P + 1)
) (
  input  logic [P-1:0]  arrive,
  input  logic [P-1:0]  proceed,
  input  logic [CW-1:0] count,
  output logic [P-1:0]  acceptMask,
  output logic [P-1:0]  rejectMask,
  output logic [CW-1:0] nAccept,
  output barStrobe_t    strobe
);
  logic [CW:0] total;

  assign acceptMask = arrive & proceed;
  assign rejectMask = arrive & ~proceed;

  always_comb begin
    nAccept = '0;
    for (int i = 0; i < P; i++) begin
      nAccept = nAccept + CW'(acceptMask[i]);
    end
  end

  assign total = {1'b0, count} + {1'b0, nAccept};
  assign strobe.anyAccept = |acceptMask;
  assign strobe.closeEpisode = strobe.anyAccept && (total == (CW + 1)'(P));
endmodule

// File: rtl/sense_barrier_dp.sv
module sense_barrier_dp
  import sense_barrier_pkg::*;
#(
  parameter int P = 4,
  localparam int CW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  barStrobe_t    strobe,
  input  logic [P-1:0]  acceptMask,
  input  logic [P-1:0]  rejectMask,
  input  logic [CW-1:0] nAccept,
  output logic [CW-1:0] count,
  output logic [P-1:0]  proceed,
  output logic          episodeDone,
  output logic [P-1:0]  arriveErr
);
  logic         globalFlag;
  logic [P-1:0] localSense;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      globalFlag <= 1'b0;
      episodeDone <= 1'b0;
    end else begin
      episodeDone <= strobe.closeEpisode;
      if (strobe.closeEpisode) begin
        count <= '0;
        globalFlag <= ~globalFlag;
      end else if (strobe.anyAccept) begin
        count <= count + nAccept;
      end
    end
  end

  for (genvar i = 0; i < P; i++) begin : gPart
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        localSense[i] <= 1'b0;
        arriveErr[i] <= 1'b0;
      end else begin
        arriveErr[i] <= rejectMask[i];
        if (acceptMask[i]) localSense[i] <= ~localSense[i];
      end
    end
    assign proceed[i] = (localSense[i] == globalFlag);
  end
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier
  import sense_barrier_pkg::*;
#(
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [P-1:0] arrive,
  output logic [P-1:0] proceed,
  output logic         episodeDone,
  output logic [P-1:0] arriveErr
);
  localparam int CW = $clog2(P + 1);

  barStrobe_t    strobe;
  logic [P-1:0]  acceptMask;
  logic [P-1:0]  rejectMask;
  logic [CW-1:0] nAccept;
  logic [CW-1:0] count;

  sense_barrier_ctrl #(.P(P)) uCtrl (
    .arrive(arrive), .proceed(proceed), .count(count),
    .acceptMask(acceptMask), .rejectMask(rejectMask),
    .nAccept(nAccept), .strobe(strobe)
  );

  sense_barrier_dp #(.P(P)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .acceptMask(acceptMask), .rejectMask(rejectMask), .nAccept(nAccept),
    .count(count), .proceed(proceed), .episodeDone(episodeDone),
    .arriveErr(arriveErr)
  );
endmodule

// File: rtl/sense_barrier_chk.sv
module sense_barrier_chk #(
  parameter int P = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [P-1:0] arrive,
  input logic [P-1:0] proceed,
  input logic         episodeDone,
  input logic [P-1:0] arriveErr
);
  // R4: a closed episode releases everyone
  assert_all_released_R4: assert property (@(posedge clk) disable iff (!rstN)
    episodeDone |-> (&proceed));

  // R6: a held participant that arrives gets an error pulse next cycle
  assert_reject_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(arrive & ~proceed)) |=> ((arriveErr & $past(arrive & ~proceed)) == $past(arrive & ~proceed)));

  // R2: proceed can only drop on a participant that arrived
  assert_drop_on_arrival_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(proceed) & ~proceed) & ~$past(arrive)) == '0));

  // R5: a release of a held participant comes with the completion pulse
  assert_release_with_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|(proceed & ~$past(proceed))) |-> episodeDone);

  // R3: no episode closes without an arrival in the cycle before
  assert_done_needs_arrival_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(episodeDone) |-> $past(|arrive));
endmodule

bind sense_barrier sense_barrier_chk #(.P(P)) uChk (.*);

// File: tb/sim_sense_barrier.sv
`timescale 1ns/1ps
module sim_sense_barrier;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] proceed;
  logic         episodeDone;
  logic [P-1:0] arriveErr;

  int checks = 0;
  int errors = 0;

  int refSense[P];
  int refFlag = 0;
  int refCount = 0;
  int expDone = 0;
  int expErr[P];

  always #2.5 clk = ~clk;

  sense_barrier #(.P(P)) u0 (
    .clk(clk), .rstN(rstN), .arrive(arrive),
    .proceed(proceed), .episodeDone(episodeDone), .arriveErr(arriveErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // compare ports against the model; called away from the rising edge
  task automatic compareAll(input string tag);
    int expProceed = 0;
    int expErrVec = 0;
    for (int i = 0; i < P; i++) begin
      if (refSense[i] == refFlag) expProceed |= (1 << i);
      if (expErr[i] != 0) expErrVec |= (1 << i);
    end
    check(int'(proceed) == expProceed, {tag, " proceed"}, int'(proceed), expProceed);
    check(int'(episodeDone) == expDone, {tag, " done"}, int'(episodeDone), expDone);
    check(int'(arriveErr) == expErrVec, {tag, " err"}, int'(arriveErr), expErrVec);
  endtask

  // apply one arrival vector for one cycle and advance the model
  task automatic step(input logic [P-1:0] vec, input string tag);
    int acc = 0;
    arrive = vec;
    for (int i = 0; i < P; i++) begin
      expErr[i] = 0;
      if (vec[i]) begin
        if (refSense[i] == refFlag) begin
          refSense[i] = 1 - refSense[i];
          acc++;
        end else begin
          expErr[i] = 1;
        end
      end
    end
    expDone = 0;
    if (acc > 0 && refCount + acc == P) begin
      refCount = 0;
      refFlag = 1 - refFlag;
      expDone = 1;
    end else begin
      refCount += acc;
    end
    @(negedge clk);
    arrive = '0;
    compareAll(tag);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [P-1:0] rnd;
    for (int i = 0; i < P; i++) begin
      refSense[i] = 0;
      expErr[i] = 0;
    end
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // R2: single arrivals are held
    step(4'b0001, "R2");
    step(4'b0000, "R2");
    // R6 / R7: duplicate from held participant rejected
    step(4'b0001, "R6");
    step(4'b0000, "R7");
    // R3: two arrivals in one cycle
    step(4'b0110, "R3");
    // R7: rejected duplicate plus a rejected repeat while one still missing
    step(4'b0011, "R7");
    // R4 / R5: last arrival closes episode
    step(4'b1000, "R4");
    step(4'b0000, "R5");
    // R8: fast participant enters next episode right away
    step(4'b0100, "R8");
    step(4'b1011, "R8");
    // R3 / R5: all at once, back to back
    step(4'b1111, "R3");
    step(4'b1111, "R5");
    step(4'b1111, "R8");
    step(4'b0000, "R5");
    // R6 mixed with closing arrivals
    step(4'b0011, "R6");
    step(4'b1101, "R6");
    step(4'b0000, "R4");

    rnd = 4'b1011;
    for (int k = 0; k < 300; k++) begin
      rnd = {rnd[2:0], rnd[3] ^ rnd[2]};
      step((k % 3 == 0) ? 4'b0000 : (rnd & 4'(k)), "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule